// File: doc/BRIEF.md
# Edge-Triggered Reset Pulse Generator

This block converts the rising edge of an asynchronous reset request into a single active-high reset pulse for one clock domain. The pulse is meant to drive the asynchronous reset pins of downstream registers. In those registers the reset test comes first and has priority over all normal sequential logic.

The pulse asserts as soon as the request edge arrives, without waiting for a clock. It is released on a rising clock edge after a two-flop synchronizer, so deassertion cannot upset downstream flops. The block reacts to a transition of the request, not to its level. A request that stays high therefore resets the domain only once. Edges that arrive while a pulse is in progress merge into that pulse.

An active-low power-on reset clears the edge capture and the synchronizer. It also forces the pulse high until the power-on reset is released.

Top module: `edge_reset_pulse`

## Requirements
- R1: While `pwr_rst_n` is 0, `rst_pulse` is 1. After `pwr_rst_n` rises between clock edges, `rst_pulse` stays 1 through the first following rising clock edge and is 0 after the second (HOLD_STAGES = 2).
- R2: With `pwr_rst_n` at 1 and no pulse active, a 0-to-1 transition of `rst_req` drives `rst_pulse` to 1 before the next rising clock edge.
- R3: Once `rst_pulse` has risen, it stays 1 for at least one full clock cycle.
- R4: `rst_pulse` falls only just after a rising clock edge. For a request edge between clock edges, it is still 1 after the third rising edge and is 0 after the fourth (SYNC_STAGES + HOLD_STAGES with defaults 2 and 2).
- R5: Holding `rst_req` at 1 after a pulse has ended causes no further pulse.
- R6: A further rising edge of `rst_req` that arrives while a pulse is active merges into that pulse. The release edge is unchanged, no glitch appears, and no second pulse follows.
- R7: After a pulse has ended and `rst_req` has been 0 for at least SYNC_STAGES + 1 clock cycles, a new rising edge produces a new pulse with the same timing as R2 and R4.
- R8: A rising edge of `rst_req` while `pwr_rst_n` is 0 is discarded. After power-on release, the pulse ends as in R1 and no request pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the domain that receives the pulse |
| pwr_rst_n | input | 1 | Active-low asynchronous power-on reset |
| rst_req | input | 1 | Asynchronous reset request; its rising edge triggers a pulse |
| rst_pulse | output | 1 | Active-high reset pulse: asynchronous assertion, synchronous release |

## Verification
The assertions assume that the request is a clean signal, with no glitches narrower than a clock cycle. They also assume that the power-on reset is released away from the active clock edge, so the release chain sees no recovery violation. The bench keeps within these limits in two ways. It changes every input at a falling clock edge or a fixed fraction of a cycle after a rising edge, never at a rising edge. It also holds the request low for several cycles before each edge that is meant to start a fresh pulse.

// File: rtl/erpg_pkg.sv
package erpg_pkg;
  localparam int unsigned SYNC_DEF = 2;  // flops in the acknowledge synchronizer
  localparam int unsigned HOLD_DEF = 2;  // flops in the release chain
endpackage

// File: rtl/erpg_capture.sv
// Edge capture: a flop clocked by the request itself, cleared from the clock domain.
module erpg_capture (
  input  logic req_i,
  input  logic clr_n_i,
  output logic capt_o
);
  logic capt_q;

  always_ff @(posedge req_i or negedge clr_n_i) begin
    if (!clr_n_i) capt_q <= 1'b0;
    else          capt_q <= 1'b1;
  end

  assign capt_o = capt_q;
endmodule

// File: rtl/erpg_ack_sync.sv
// Brings the captured edge into the clock domain; its output clears the capture flop.
module erpg_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic capt_i,
  output logic ack_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = capt_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], capt_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign ack_o = sync_q[STAGES-1];
endmodule

// File: rtl/erpg_release.sv
// Release chain: asynchronously set, shifts zeros in on each clock edge.
module erpg_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic set_i,
  output logic pulse_o
);
  logic [STAGES-1:0] hold_q;
  logic [STAGES-1:0] hold_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb hold_d = 1'b0;
    end else begin : g_chain
      always_comb hold_d = {hold_q[STAGES-2:0], 1'b0};
    end
  endgenerate

  always_ff @(posedge clk_i or posedge set_i) begin
    if (set_i) hold_q <= '1;
    else       hold_q <= hold_d;
  end

  assign pulse_o = hold_q[STAGES-1];
endmodule

// File: rtl/edge_reset_pulse.sv
module edge_reset_pulse #(
  parameter int unsigned SYNC_STAGES = erpg_pkg::SYNC_DEF,
  parameter int unsigned HOLD_STAGES = erpg_pkg::HOLD_DEF
) (
  input  logic clk,
  input  logic pwr_rst_n,
  input  logic rst_req,
  output logic rst_pulse
);
  logic capt;
  logic ack;
  logic capt_clr_n;
  logic chain_set;

  // Capture is held clear during power-up and while the clock domain acknowledges it.
  assign capt_clr_n = pwr_rst_n & ~ack;
  // Chain is forced set by a captured edge or by power-up.
  assign chain_set  = capt | ~pwr_rst_n;

  erpg_capture u_capture (
    .req_i   (rst_req),
    .clr_n_i (capt_clr_n),
    .capt_o  (capt)
  );

  erpg_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk_i   (clk),
    .por_n_i (pwr_rst_n),
    .capt_i  (capt),
    .ack_o   (ack)
  );

  erpg_release #(.STAGES(HOLD_STAGES)) u_release (
    .clk_i   (clk),
    .set_i   (chain_set),
    .pulse_o (rst_pulse)
  );

  AST_POWERUP_ASSERTED: assert property (@(posedge clk) !pwr_rst_n |-> rst_pulse); // R1
  AST_CAPTURE_DRIVES_PULSE: assert property (@(posedge clk) disable iff (!pwr_rst_n) capt |-> rst_pulse); // R2
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!pwr_rst_n) $rose(rst_pulse) |=> rst_pulse); // R3
  AST_ACK_CLEARS_CAPTURE: assert property (@(posedge clk) disable iff (!pwr_rst_n) ack |-> !capt); // R6
endmodule

// File: tb/edge_reset_pulse_bench.sv
`timescale 1ns/1ps
module edge_reset_pulse_bench;
  logic clk = 1'b0;
  logic pwr_rst_n;
  logic rst_req;
  logic rst_pulse;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  edge_reset_pulse u_edge_reset_pulse (
    .clk       (clk),
    .pwr_rst_n (pwr_rst_n),
    .rst_req   (rst_req),
    .rst_pulse (rst_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_pulse=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a request edge at a falling clock edge and check the full pulse timing.
  task automatic run_pulse(input string req);
    @(negedge clk); rst_req = 1'b1;
    #1 chk({req, " R2 async assert"}, rst_pulse, 1'b1);
    repeat (3) @(posedge clk);
    #1 chk({req, " R3 held after third edge"}, rst_pulse, 1'b1);
    @(negedge clk) chk({req, " R4 high before release edge"}, rst_pulse, 1'b1);
    @(posedge clk); #1 chk({req, " R4 released on fourth edge"}, rst_pulse, 1'b0);
  endtask

  task automatic stay_low(input string req, input int cycles);
    bit bad = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_pulse !== 1'b0) bad = 1'b1;
    end
    chk(req, bad ? 1'b1 : 1'b0, 1'b0);
  endtask

  task automatic t_powerup();
    pwr_rst_n = 1'b0; rst_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R1 asserted during power-up", rst_pulse, 1'b1);
    @(negedge clk); pwr_rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 held after first edge", rst_pulse, 1'b1);
    @(posedge clk); #1 chk("R1 released after second edge", rst_pulse, 1'b0);
    stay_low("R1 stays low after release", 5);
  endtask

  task automatic t_single_and_held();
    run_pulse("single");
    stay_low("R5 held request gives no new pulse", 20);
    @(negedge clk); rst_req = 1'b0;
    stay_low("R5 falling request gives no pulse", 6);
  endtask

  task automatic t_rearm();
    run_pulse("R7 rearm");
    @(negedge clk); rst_req = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_merge();
    @(negedge clk); rst_req = 1'b1;
    #1 chk("R6 first edge asserts", rst_pulse, 1'b1);
    @(posedge clk); #1 rst_req = 1'b0;
    @(negedge clk); rst_req = 1'b1;   // edge while capture still set
    @(posedge clk); #1 rst_req = 1'b0;
    @(negedge clk); rst_req = 1'b1;   // edge while acknowledge clears capture
    #1 chk("R6 no glitch mid-pulse", rst_pulse, 1'b1);
    @(posedge clk); #1 chk("R6 held after third edge", rst_pulse, 1'b1);
    @(posedge clk); #1 chk("R6 release edge unchanged", rst_pulse, 1'b0);
    stay_low("R6 no second pulse", 12);
    @(negedge clk); rst_req = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_edge_in_powerup();
    @(negedge clk); pwr_rst_n = 1'b0;
    #1 chk("R1 power-up asserts at once", rst_pulse, 1'b1);
    @(negedge clk); rst_req = 1'b1;
    repeat (2) @(negedge clk);
    pwr_rst_n = 1'b1;
    @(posedge clk); #1 chk("R8 held after first edge", rst_pulse, 1'b1);
    @(posedge clk); #1 chk("R8 released after second edge", rst_pulse, 1'b0);
    stay_low("R8 discarded edge gives no pulse", 12);
    @(negedge clk); rst_req = 1'b0;
    repeat (5) @(negedge clk);
    run_pulse("R8 recovery");
    @(negedge clk); rst_req = 1'b0;
  endtask

  initial begin
    t_powerup();
    t_single_and_held();
    t_rearm();
    t_merge();
    t_edge_in_powerup();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual done=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule